// File: doc/BRIEF.md
# Lazy Block Re-encryption Controller

This controller sits beside an encrypting memory path whose one-time pads are derived from a cache-line address and an epoch value. It keeps a global epoch counter that counts resumes since the last reboot. It also keeps one epoch stamp per group of contiguous cache lines, called a memory block. A line is always stored encrypted under the pad for its block's stamp, so a stamp that is shared by many lines forces the whole group forward together. That happens the first time the group is written after a resume.

When the processor presents a write to a block whose stamp differs from the epoch, the controller raises stall and takes over the memory port. It walks the block's lines in ascending order. For each line it reads the ciphertext, hands it to the external pad datapath, which strips the old pad and applies the new one, and writes the result back. It then stamps the block and lets the write through. Reads never trigger this work: they are told which stamp to decrypt with. The epoch saturates instead of wrapping, and at that point it asks for a reboot, so that no pad is ever used twice.

The state machine has six states:

| State | Role |
|---|---|
| WS_IDLE | Serves requests |
| WS_RD_ISSUE | Issues one memory read |
| WS_RD_WAIT | Waits for the read data |
| WS_PAD | Waits for the pad transform |
| WS_WR | Writes the line back |
| WS_STAMP | Updates the block's stamp |

The transitions between them are:

| From | Condition | To |
|---|---|---|
| WS_IDLE | A stale write arrives | WS_RD_ISSUE |
| WS_RD_ISSUE | Always | WS_RD_WAIT |
| WS_RD_WAIT | `mem_rvalid` | WS_PAD |
| WS_PAD | `pad_ack` | WS_WR |
| WS_WR | Not the last line of the block | WS_RD_ISSUE |
| WS_WR | Last line of the block | WS_STAMP |
| WS_STAMP | Always | WS_IDLE |
| Any state | Reboot | WS_IDLE |

Top module: `lazy_rekey_ctrl`

## Requirements
- R1: After reset or a one-cycle `reboot`, the epoch is 0, every block stamp is 0 and `reboot_needed` is 0. A reboot during a walk abandons it and returns the controller to idle in the next cycle.
- R2: Each clock cycle in which `resume` is high and `reboot` is low raises the epoch by exactly 1. With both low, the epoch holds.
- R3: When the epoch is at its maximum (65535 by default), a further resume leaves the epoch unchanged and sets `reboot_needed`. The flag stays set until reset or reboot.
- R4: A write request to a block whose stamp differs from the epoch drives `req_stall` high in the same cycle and starts a walk of that block. Block index = `req_line` >> GRP_LOG2.
- R5: A walk re-encrypts exactly the 2^GRP_LOG2 lines of the block, in ascending line order, and touches no other line. For each line it makes one read, one pad transform from the old stamp to the new stamp, and one write-back to the same line. `pad_req` is held until `pad_ack`, and `pad_dout` is valid in the ack cycle.
- R6: After a walk, the block's stamp equals the epoch latched when the walk began. A later write to the same block within the same resume is accepted without stall and without memory traffic.
- R7: An accepted write reports `req_ts` equal to the current epoch.
- R8: When no walk is running, a read is never stalled. It reports `req_ts` equal to the stored stamp of its block and causes no memory access, even if that block is stale.
- R9: Once a walk starts, `req_stall` stays high until the walk and its stamp update complete.
- R10: If a resume lands in the cycle where a stale write is detected, the walk uses the pre-increment epoch. The block is then still stale, so a second walk follows before the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reboot | input | 1 | One-cycle reboot pulse; clears epoch and stamps |
| resume | input | 1 | Advances the epoch once per high cycle |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_line | input | LINE_AW | Cache-line address of the request |
| req_stall | output | 1 | Request must be held; accepted in a cycle where this is low |
| req_ts | output | CNT_W | Epoch whose pad applies to the request |
| epoch | output | CNT_W | Current global epoch |
| reboot_needed | output | 1 | Epoch exhausted; a reboot is required |
| mem_rd | output | 1 | One-cycle read command during a walk |
| mem_wr | output | 1 | One-cycle write command during a walk |
| mem_line | output | LINE_AW | Line address for the walk command |
| mem_wdata | output | DATA_W | Re-encrypted line data |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid |
| pad_req | output | 1 | Pad transform requested |
| pad_line | output | LINE_AW | Line whose pads are needed |
| pad_ts_old | output | CNT_W | Stamp the data is encrypted under |
| pad_ts_new | output | CNT_W | Epoch to re-encrypt under |
| pad_din | output | DATA_W | Ciphertext under the old pad |
| pad_ack | input | 1 | Transform complete |
| pad_dout | input | DATA_W | Ciphertext under the new pad |

## Verification
Two functions can fall in the same cycle: a resume advancing the epoch, and the idle state latching the epoch for a freshly detected stale write. The bench provokes this by raising `resume` in the cycle in which it presents the stale write. It then expects two complete walks, eight write-backs by default, before the write is accepted with `req_ts` equal to the new epoch. It judges the result by comparing every line of the block against the plaintext combined with the pad for the final stamp. A reboot landing inside a walk is a second such collision, and it is judged by the stall dropping one cycle later.

// File: rtl/lazy_rekey_pkg.sv
package lazy_rekey_pkg;

    // Walk sequencer states
    typedef enum logic [2:0] {
        WS_IDLE     = 3'd0,
        WS_RD_ISSUE = 3'd1,
        WS_RD_WAIT  = 3'd2,
        WS_PAD      = 3'd3,
        WS_WR       = 3'd4,
        WS_STAMP    = 3'd5
    } walk_state_e;

endpackage

// File: rtl/epoch_counter.sv
// Global resume counter: cleared by reset/reboot, saturating, with exhaustion flag.
module epoch_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reboot,
    input  logic             resume,
    output logic [CNT_W-1:0] epoch,
    output logic             exhausted
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             exh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exh_q <= 1'b0;
        end else if (reboot) begin
            cnt_q <= '0;
            exh_q <= 1'b0;
        end else if (resume) begin
            if (cnt_q == CNT_MAX) begin
                // never wrap: a wrapped epoch would repeat pads
                exh_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign epoch     = cnt_q;
    assign exhausted = exh_q;
endmodule

// File: rtl/stamp_table.sv
// One epoch stamp per memory block, one register per entry.
module stamp_table #(
    parameter int BLK_AW = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [BLK_AW-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_ts,
    input  logic              wr_en,
    input  logic [BLK_AW-1:0] wr_idx,
    input  logic [CNT_W-1:0]  wr_ts
);
    localparam int NBLK = 1 << BLK_AW;

    logic [CNT_W-1:0] ent [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_ent
        logic [CNT_W-1:0] ts_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ts_q <= '0;
            end else if (clear) begin
                ts_q <= '0;
            end else if (wr_en && (wr_idx == BLK_AW'(g))) begin
                ts_q <= wr_ts;
            end
        end
        assign ent[g] = ts_q;
    end

    assign rd_ts = ent[rd_idx];
endmodule

// File: rtl/walk_fsm.sv
// Request gating and per-block re-encryption walk.
module walk_fsm
    import lazy_rekey_pkg::*;
#(
    parameter int LINE_AW = 8,
    parameter int GRP_LOG2 = 2,
    parameter int CNT_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        abort,
    input  logic                        req_valid,
    input  logic                        req_we,
    input  logic [LINE_AW-1:0]          req_line,
    input  logic [CNT_W-1:0]            epoch,
    input  logic [CNT_W-1:0]            cur_ts,
    output logic                        req_stall,
    output logic [CNT_W-1:0]            req_ts,
    output logic                        st_wr_en,
    output logic [LINE_AW-GRP_LOG2-1:0] st_wr_idx,
    output logic [CNT_W-1:0]            st_wr_ts,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic [LINE_AW-1:0]          mem_line,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_rvalid,
    output logic                        pad_req,
    output logic [LINE_AW-1:0]          pad_line,
    output logic [CNT_W-1:0]            pad_ts_old,
    output logic [CNT_W-1:0]            pad_ts_new,
    output logic [DATA_W-1:0]           pad_din,
    input  logic                        pad_ack,
    input  logic [DATA_W-1:0]           pad_dout,
    output logic                        busy
);
    localparam logic [LINE_AW-1:0] GRP_MASK = LINE_AW'((1 << GRP_LOG2) - 1);

    walk_state_e        state_q, state_d;
    logic [LINE_AW-1:0] line_q;
    logic [CNT_W-1:0]   old_q, new_q;
    logic [DATA_W-1:0]  data_q;
    logic               stale_wr;
    logic               last_line;

    assign stale_wr  = req_valid && req_we && (cur_ts != epoch);
    assign last_line = ((line_q & GRP_MASK) == GRP_MASK);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:     if (stale_wr)   state_d = WS_RD_ISSUE;
            WS_RD_ISSUE:                 state_d = WS_RD_WAIT;
            WS_RD_WAIT:  if (mem_rvalid) state_d = WS_PAD;
            WS_PAD:      if (pad_ack)    state_d = WS_WR;
            WS_WR:       state_d = last_line ? WS_STAMP : WS_RD_ISSUE;
            WS_STAMP:                    state_d = WS_IDLE;
            default:                     state_d = WS_IDLE;
        endcase
        if (abort) state_d = WS_IDLE;
    end

    // State register and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            line_q  <= '0;
            old_q   <= '0;
            new_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!abort) begin
                unique case (state_q)
                    WS_IDLE: if (stale_wr) begin
                        line_q <= req_line & ~GRP_MASK;
                        old_q  <= cur_ts;
                        new_q  <= epoch;
                    end
                    WS_RD_WAIT: if (mem_rvalid) data_q <= mem_rdata;
                    WS_PAD:     if (pad_ack)    data_q <= pad_dout;
                    WS_WR:      if (!last_line) line_q <= line_q + LINE_AW'(1);
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != WS_IDLE);
        req_stall  = busy || stale_wr;
        req_ts     = req_we ? epoch : cur_ts;
        mem_rd     = (state_q == WS_RD_ISSUE);
        mem_wr     = (state_q == WS_WR);
        mem_line   = line_q;
        mem_wdata  = data_q;
        pad_req    = (state_q == WS_PAD);
        pad_line   = line_q;
        pad_ts_old = old_q;
        pad_ts_new = new_q;
        pad_din    = data_q;
        st_wr_en   = (state_q == WS_STAMP);
        st_wr_idx  = line_q[LINE_AW-1:GRP_LOG2];
        st_wr_ts   = new_q;
    end
endmodule

// File: rtl/lazy_rekey_ctrl.sv
// Top: epoch counter, block stamp table and walk sequencer.
module lazy_rekey_ctrl #(
    parameter int LINE_AW = 8,
    parameter int GRP_LOG2 = 2,
    parameter int CNT_W = 16,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reboot,
    input  logic               resume,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [LINE_AW-1:0] req_line,
    output logic               req_stall,
    output logic [CNT_W-1:0]   req_ts,
    output logic [CNT_W-1:0]   epoch,
    output logic               reboot_needed,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [LINE_AW-1:0] mem_line,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_rvalid,
    output logic               pad_req,
    output logic [LINE_AW-1:0] pad_line,
    output logic [CNT_W-1:0]   pad_ts_old,
    output logic [CNT_W-1:0]   pad_ts_new,
    output logic [DATA_W-1:0]  pad_din,
    input  logic               pad_ack,
    input  logic [DATA_W-1:0]  pad_dout
);
    localparam int BLK_AW = LINE_AW - GRP_LOG2;

    logic [CNT_W-1:0]  cur_ts;
    logic              st_wr_en;
    logic [BLK_AW-1:0] st_wr_idx;
    logic [CNT_W-1:0]  st_wr_ts;
    logic              walk_busy;

    epoch_counter #(.CNT_W(CNT_W)) u_epoch (
        .clk       (clk),
        .rst_n     (rst_n),
        .reboot    (reboot),
        .resume    (resume),
        .epoch     (epoch),
        .exhausted (reboot_needed)
    );

    stamp_table #(.BLK_AW(BLK_AW), .CNT_W(CNT_W)) u_stamps (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (reboot),
        .rd_idx (req_line[LINE_AW-1:GRP_LOG2]),
        .rd_ts  (cur_ts),
        .wr_en  (st_wr_en),
        .wr_idx (st_wr_idx),
        .wr_ts  (st_wr_ts)
    );

    walk_fsm #(
        .LINE_AW (LINE_AW),
        .GRP_LOG2(GRP_LOG2),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (reboot),
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_line   (req_line),
        .epoch      (epoch),
        .cur_ts     (cur_ts),
        .req_stall  (req_stall),
        .req_ts     (req_ts),
        .st_wr_en   (st_wr_en),
        .st_wr_idx  (st_wr_idx),
        .st_wr_ts   (st_wr_ts),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_line   (mem_line),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .pad_req    (pad_req),
        .pad_line   (pad_line),
        .pad_ts_old (pad_ts_old),
        .pad_ts_new (pad_ts_new),
        .pad_din    (pad_din),
        .pad_ack    (pad_ack),
        .pad_dout   (pad_dout),
        .busy       (walk_busy)
    );
endmodule

// File: rtl/lazy_rekey_ctrl_sva.sv
module lazy_rekey_ctrl_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reboot,
    input logic             resume,
    input logic             req_valid,
    input logic             req_we,
    input logic             req_stall,
    input logic [CNT_W-1:0] epoch,
    input logic             reboot_needed,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             pad_req,
    input logic [CNT_W-1:0] pad_ts_old,
    input logic [CNT_W-1:0] pad_ts_new,
    input logic             busy
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_REBOOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |=> (epoch == '0 && !reboot_needed && !busy)); // R1
    AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!reboot && resume && epoch != CNT_MAX) |=> (epoch == CNT_W'($past(epoch) + CNT_W'(1)))); // R2
    AST_EPOCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reboot && !resume) |=> $stable(epoch)); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!reboot && resume && epoch == CNT_MAX) |=> (epoch == CNT_MAX && reboot_needed)); // R3
    AST_ONE_MEM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(pad_req && (mem_rd || mem_wr))); // R5
    AST_PAD_EPOCH_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        pad_req |-> (pad_ts_old != pad_ts_new)); // R5
    AST_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !req_we) |-> !req_stall); // R8
    AST_WALK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> req_stall); // R9
endmodule

bind lazy_rekey_ctrl lazy_rekey_ctrl_sva #(.CNT_W(CNT_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .reboot        (reboot),
    .resume        (resume),
    .req_valid     (req_valid),
    .req_we        (req_we),
    .req_stall     (req_stall),
    .epoch         (epoch),
    .reboot_needed (reboot_needed),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .pad_req       (pad_req),
    .pad_ts_old    (pad_ts_old),
    .pad_ts_new    (pad_ts_new),
    .busy          (walk_busy)
);

// File: tb/test_lazy_rekey_ctrl.sv
module test_lazy_rekey_ctrl;
    localparam int LINES = 256;
    localparam int GRP   = 4;
    localparam int NBLK  = LINES / GRP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reboot = 1'b0, resume = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [7:0]  req_line = '0;
    logic        req_stall;
    logic [15:0] req_ts, epoch;
    logic        reboot_needed;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_line;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        pad_req;
    logic [7:0]  pad_line;
    logic [15:0] pad_ts_old, pad_ts_new;
    logic [31:0] pad_din;
    logic        pad_ack = 1'b0;
    logic [31:0] pad_dout;

    always #5 clk = ~clk;

    lazy_rekey_ctrl i_lazy_rekey_ctrl (
        .clk(clk), .rst_n(rst_n), .reboot(reboot), .resume(resume),
        .req_valid(req_valid), .req_we(req_we), .req_line(req_line),
        .req_stall(req_stall), .req_ts(req_ts), .epoch(epoch),
        .reboot_needed(reboot_needed), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_line(mem_line), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .pad_req(pad_req), .pad_line(pad_line),
        .pad_ts_old(pad_ts_old), .pad_ts_new(pad_ts_new), .pad_din(pad_din),
        .pad_ack(pad_ack), .pad_dout(pad_dout)
    );

    function automatic logic [31:0] padf(input logic [7:0] l, input logic [15:0] t);
        logic [31:0] h;
        h = ({24'd0, l} * 32'h9E3779B1) ^ ({16'd0, t} * 32'h85EBCA6B) ^ 32'hC3A50F1E;
        return {h[18:0], h[31:19]} ^ {16'd0, t};
    endfunction

    // bench-side memory and pad datapath
    logic [31:0] mem [LINES];
    logic [31:0] plain [LINES];
    logic        rd_p1 = 1'b0;
    logic [7:0]  rd_l1 = '0;
    int          wr_cnt = 0, rd_cnt = 0;
    logic        host_wr = 1'b0, mem_init = 1'b0;
    logic [7:0]  host_line = '0;
    logic [31:0] host_data = '0;

    assign pad_dout = pad_din ^ padf(pad_line, pad_ts_old) ^ padf(pad_line, pad_ts_new);

    always @(posedge clk) begin
        rd_p1      <= mem_rd;
        rd_l1      <= mem_line;
        mem_rvalid <= rd_p1;
        mem_rdata  <= mem[rd_l1];
        pad_ack    <= pad_req && !pad_ack;
        if (mem_rd) rd_cnt <= rd_cnt + 1;
        if (mem_wr) begin
            mem[mem_line] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (host_wr) mem[host_line] <= host_data;
        if (mem_init)
            for (int i = 0; i < LINES; i++) mem[i] <= plain[i] ^ padf(8'(i), 16'd0);
    end

    // reference model
    logic [15:0] cnt_m = '0;
    logic        flag_m = 1'b0;
    logic [15:0] tsm [NBLK];
    int total = 0, bad = 0;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        cnt_m = '0;
        flag_m = 1'b0;
        for (int b = 0; b < NBLK; b++) tsm[b] = '0;
    endtask

    task automatic reinit_mem();
        @(negedge clk); mem_init = 1'b1;
        @(negedge clk); mem_init = 1'b0;
    endtask

    task automatic model_resume();
        if (cnt_m == 16'hFFFF) flag_m = 1'b1;
        else cnt_m = cnt_m + 16'd1;
    endtask

    task automatic check_block(input int b, input string rq);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < GRP; k++)
            if (mem[b*GRP+k] !== (plain[b*GRP+k] ^ padf(8'(b*GRP+k), tsm[b]))) ok = 1'b0;
        chk(rq, {63'd0, ok}, 64'd1, $sformatf("block %0d contents", b));
    endtask

    task automatic pulse_resume();
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        model_resume();
        chk("R2", {48'd0, epoch}, {48'd0, cnt_m}, "epoch after resume");
    endtask

    task automatic do_reboot();
        @(negedge clk); reboot = 1'b1;
        @(negedge clk); reboot = 1'b0;
        model_clear();
        chk("R1", {47'd0, reboot_needed, epoch}, 64'd0, "epoch/flag after reboot");
        reinit_mem();
    endtask

    // issue one request, hold until accepted; returns first stall, stall count, req_ts
    task automatic do_req(input logic we, input logic [7:0] line, input logic with_res,
                          output logic first_stall, output int stalls, output logic [15:0] ts);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_line = line; resume = with_res;
        #1;
        first_stall = req_stall;
        stalls = 0;
        while (req_stall) begin
            @(negedge clk);
            resume = 1'b0;
            stalls++;
            #1;
        end
        ts = req_ts;
        @(posedge clk);
        #1;
        req_valid = 1'b0; resume = 1'b0;
    endtask

    task automatic op_write(input logic [7:0] line, input logic [31:0] data, input logic with_res);
        int b, walks, stalls, w0;
        logic stale, fs;
        logic [15:0] ts, exp_ts, cnt_new;
        b = int'(line) / GRP;
        stale = (tsm[b] != cnt_m);
        cnt_new = (with_res && cnt_m != 16'hFFFF) ? cnt_m + 16'd1 : cnt_m;
        if (!stale) begin
            walks = 0; exp_ts = cnt_m;
        end else begin
            walks = (cnt_new != cnt_m) ? 2 : 1;
            exp_ts = cnt_new;
            tsm[b] = cnt_new;
        end
        if (with_res) model_resume();
        w0 = wr_cnt;
        do_req(1'b1, line, with_res, fs, stalls, ts);
        chk("R4", {63'd0, fs}, {63'd0, stale}, $sformatf("first-cycle stall, line %0d", line));
        chk(walks == 2 ? "R10" : "R5", 64'(wr_cnt - w0), 64'(walks * GRP), "walk write-backs");
        chk("R9", {63'd0, stalls >= walks * GRP * 6}, 64'd1, $sformatf("stall held %0d cycles", stalls));
        chk(stale ? "R6" : "R7", {48'd0, ts}, {48'd0, exp_ts}, "write req_ts");
        check_block(b, "R5");
        @(negedge clk);
        host_wr = 1'b1; host_line = line; host_data = data ^ padf(line, exp_ts);
        @(negedge clk);
        host_wr = 1'b0;
        plain[line] = data;
    endtask

    task automatic op_read(input logic [7:0] line);
        int b, stalls, r0;
        logic fs;
        logic [15:0] ts;
        b = int'(line) / GRP;
        r0 = rd_cnt;
        do_req(1'b0, line, 1'b0, fs, stalls, ts);
        chk("R8", {63'd0, fs}, 64'd0, $sformatf("read stall, line %0d", line));
        chk("R8", {48'd0, ts}, {48'd0, tsm[b]}, "read req_ts");
        @(negedge clk);
        chk("R8", 64'(rd_cnt - r0), 64'd0, "read caused memory traffic");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LINES; i++) plain[i] = $urandom;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reinit_mem();

        // R1: reset state
        chk("R1", {47'd0, reboot_needed, epoch}, 64'd0, "epoch/flag after reset");
        op_read(8'd0);

        // R2, R4, R5, R7: first write after a resume
        pulse_resume();
        op_write(8'd9, 32'hA5A5_0001, 1'b0);
        // R6: same block again, same resume
        op_write(8'd10, 32'h0BAD_F00D, 1'b0);
        // R8: stale block read
        op_read(8'd40);
        // R10: resume coincides with stale write detection
        op_write(8'd41, 32'h1234_5678, 1'b1);

        // R1: reboot in the middle of a walk
        pulse_resume();
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_line = 8'd21;
        repeat (4) @(negedge clk);
        reboot = 1'b1;
        @(negedge clk);
        reboot = 1'b0;
        #1;
        chk("R1", {63'd0, req_stall}, 64'd0, "stall after reboot during walk");
        @(posedge clk); #1; req_valid = 1'b0;
        model_clear();
        reinit_mem();

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            int sel;
            sel = int'($urandom % 8);
            if (sel < 2) pulse_resume();
            else if (sel < 5) op_write(8'($urandom), $urandom, ($urandom % 6) == 0);
            else op_read(8'($urandom));
        end
        for (int b = 0; b < NBLK; b++) check_block(b, "R5");

        // R3: drive epoch to its limit, then one more resume
        @(negedge clk); resume = 1'b1;
        repeat (int'(16'hFFFF - cnt_m)) @(negedge clk);
        resume = 1'b0;
        cnt_m = 16'hFFFF;
        chk("R3", {47'd0, reboot_needed, epoch}, {47'd0, 1'b0, 16'hFFFF}, "epoch at limit");
        pulse_resume();
        chk("R3", {63'd0, reboot_needed}, 64'd1, "exhaustion flag");
        op_write(8'd200, 32'hFEED_BEEF, 1'b0);
        chk("R3", {47'd0, reboot_needed, epoch}, {47'd0, 1'b1, 16'hFFFF}, "flag and epoch stay");

        // R1: reboot clears everything
        do_reboot();
        op_read(8'd200);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule